// File: doc/BRIEF.md
# Serial Flash Power-Mode Command Controller

This block sits on the slave side of a serial flash model and owns the device power state. It oversamples the active-low chip select, the serial clock and the single data line with the local clock `clk_i`. From those samples it collects 8-bit opcodes, each frame on its own, and decides whether a frame is a valid request to enter deep power-down or to leave it. The entry and exit delays run as local clock-cycle counts.

The controller has four states: standby, entering, deep and leaving. The state is reported as a 2-bit code, and a separate accept flag tells the other command decoders when they may act. A `busy_i` input comes from the erase/program/write engine. While it is high, both power opcodes are refused and the running cycle is left alone. If chip select falls while the exit delay is still running, a sticky protocol-error flag is set. That frame is dropped, and the exit still completes.

Top module: `flash_pwr_ctrl`

## Requirements
- R1: After `rst_ni` is released, the state code is 00 (standby), `accept_cmd_o` is 1 and `proto_err_o` is 0.
- R2: The state codes are 00 standby, 01 entering, 10 deep and 11 leaving. `accept_cmd_o` is high only while the code is 00. The code only ever steps along 00, 01, 10, 11, 00.
- R3: An opcode is shifted in MSB first, one bit per rising `sclk_i` edge while `cs_ni` is low. In standby, opcode 0xB9 starts entry only if exactly 8 rising edges came before `cs_ni` rises. A frame with 7 or 9 edges leaves the state at 00.
- R4: After a valid entry frame, the state stays at 01 for exactly T_DP clock cycles and then goes to 10.
- R5: In deep power-down, every frame other than a valid 0xAB release leaves the state at 10. This includes 0xB9 and any other byte.
- R6: A 0xAB release with 7 or 9 rising clock edges before `cs_ni` rises is rejected, and the state stays at 10.
- R7: After a valid release frame, the state stays at 11 for exactly T_RDP clock cycles and then goes to 00.
- R8: If `busy_i` is high in the cycle a frame is judged, a 0xB9 frame in standby or a 0xAB frame in deep power-down is rejected, and the state does not change.
- R9: A falling `cs_ni` judged while the state is 11 sets `proto_err_o`. The return to 00 still completes, and that frame has no effect. The flag stays high until a later `cs_ni` fall is judged in standby.
- R10: `cs_ni`, `sclk_i` and `sdi_i` each pass through a two-stage synchronizer. A `cs_ni` edge applied before a rising `clk_i` edge is acted on at the fourth rising `clk_i` edge.
- R11: In standby, a valid 0xAB frame or any byte other than 0xB9 leaves the state at 00.
- R12: A frame whose `cs_ni` fall is judged while the state is 01 or 11 is discarded, even if it ends after the state has moved on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data input |
| busy_i | input | 1 | Erase/program/write cycle running |
| pwr_state_o | output | 2 | Power state code |
| accept_cmd_o | output | 1 | Other commands may be decoded |
| proto_err_o | output | 1 | Chip select fell during the exit delay |

## Verification
Two events can fall in the same cycle: the end of the exit delay, and the judgement of a new chip-select fall. When both land on one edge, the frame must still be counted as an error and discarded, and the exit must still reach standby. The bench lowers `cs_ni` at a sweep of offsets that straddle the last cycles of the exit wait. For each offset it reads the state in the cycle in which that fall is judged, predicts the error flag from it, and then checks that standby is reached.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int unsigned OPC_W = 8;

  typedef enum logic [1:0] {
    PS_STANDBY  = 2'b00,
    PS_ENTERING = 2'b01,
    PS_DEEP     = 2'b10,
    PS_LEAVING  = 2'b11
  } pwr_state_e;

  typedef struct packed {
    logic             len_ok;
    logic [OPC_W-1:0] opcode;
  } frame_t;
endpackage

// File: rtl/fpc_sync.sv
module fpc_sync #(
  parameter int unsigned     WIDTH   = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fpc_frame_rx.sv
module fpc_frame_rx
  import fpc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cs_s_i,
  input  logic   sclk_s_i,
  input  logic   sdi_s_i,
  output logic   frame_start_o,
  output logic   frame_end_o,
  output frame_t frame_o
);
  localparam int unsigned CNT_W   = $clog2(OPC_W + 2);
  localparam int unsigned CNT_SAT = OPC_W + 1;

  logic             cs_q, sclk_q;
  logic [OPC_W-1:0] shift_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cs_fall, cs_rise, sclk_rise;

  assign cs_fall   =  cs_q & ~cs_s_i;
  assign cs_rise   = ~cs_q &  cs_s_i;
  assign sclk_rise =  sclk_s_i & ~sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_s_i;
      sclk_q <= sclk_s_i;
    end
  end

  // deselect wipes the frame so every frame is decoded alone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (cs_s_i) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (sclk_rise) begin
      shift_q <= {shift_q[OPC_W-2:0], sdi_s_i};
      if (cnt_q != CNT_W'(CNT_SAT)) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_start_o <= 1'b0;
      frame_end_o   <= 1'b0;
      frame_o       <= '0;
    end else begin
      frame_start_o  <= cs_fall;
      frame_end_o    <= cs_rise;
      frame_o.len_ok <= (cnt_q == CNT_W'(OPC_W));
      frame_o.opcode <= shift_q;
    end
  end
endmodule

// File: rtl/fpc_delay_timer.sv
module fpc_delay_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= val_i;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/flash_pwr_ctrl.sv
module flash_pwr_ctrl
  import fpc_pkg::*;
#(
  parameter logic [OPC_W-1:0] OPC_ENTER   = 8'hB9,
  parameter logic [OPC_W-1:0] OPC_RELEASE = 8'hAB,
  parameter int unsigned      T_DP        = 24,
  parameter int unsigned      T_RDP       = 40,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sclk_i,
  input  logic       sdi_i,
  input  logic       busy_i,
  output logic [1:0] pwr_state_o,
  output logic       accept_cmd_o,
  output logic       proto_err_o
);
  localparam int unsigned T_MAX = (T_DP > T_RDP) ? T_DP : T_RDP;
  localparam int unsigned TMR_W = $clog2(T_MAX + 1);

  logic [2:0]       pins_s;
  logic             frame_start, frame_end;
  frame_t           frame;
  pwr_state_e       state_q, state_d;
  logic             tmr_load, tmr_done;
  logic [TMR_W-1:0] tmr_val;
  logic             void_q, err_q;
  logic             enter_ok, release_ok;

  fpc_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdi_i}),
    .q_o   (pins_s)
  );

  fpc_frame_rx u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_s_i       (pins_s[2]),
    .sclk_s_i     (pins_s[1]),
    .sdi_s_i      (pins_s[0]),
    .frame_start_o(frame_start),
    .frame_end_o  (frame_end),
    .frame_o      (frame)
  );

  fpc_delay_timer #(.CNT_W(TMR_W)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .val_i (tmr_val),
    .done_o(tmr_done)
  );

  // a frame is judged only if it began in a stable state and no cycle is running
  assign enter_ok   = frame_end && !void_q && frame.len_ok && !busy_i &&
                      (frame.opcode == OPC_ENTER);
  assign release_ok = frame_end && !void_q && frame.len_ok && !busy_i &&
                      (frame.opcode == OPC_RELEASE);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      PS_STANDBY: if (enter_ok) begin
        state_d  = PS_ENTERING;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(T_DP - 1);
      end
      PS_ENTERING: if (tmr_done) state_d = PS_DEEP;
      PS_DEEP: if (release_ok) begin
        state_d  = PS_LEAVING;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(T_RDP - 1);
      end
      PS_LEAVING: if (tmr_done) state_d = PS_STANDBY;
      default: state_d = PS_STANDBY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PS_STANDBY;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      void_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (frame_start) begin
      void_q <= (state_q == PS_ENTERING) || (state_q == PS_LEAVING);
      if (state_q == PS_LEAVING)      err_q <= 1'b1;
      else if (state_q == PS_STANDBY) err_q <= 1'b0;
    end
  end

  assign pwr_state_o  = state_q;
  assign accept_cmd_o = (state_q == PS_STANDBY);
  assign proto_err_o  = err_q;
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker
  import fpc_pkg::*;
#(
  parameter int unsigned T_DP  = 24,
  parameter int unsigned T_RDP = 40
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic [1:0] pwr_state_o,
  input logic       proto_err_o
);
  int unsigned dwell_ent_q, dwell_lv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dwell_ent_q <= 0;
      dwell_lv_q  <= 0;
    end else begin
      dwell_ent_q <= (pwr_state_o == PS_ENTERING) ? dwell_ent_q + 1 : 0;
      dwell_lv_q  <= (pwr_state_o == PS_LEAVING)  ? dwell_lv_q + 1  : 0;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_STANDBY: assert (pwr_state_o == PS_STANDBY && !proto_err_o); // R1
    end
  end

  AST_STEP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o != $past(pwr_state_o)) |-> (pwr_state_o == $past(pwr_state_o) + 2'd1)); // R2

  AST_ENTRY_DWELL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pwr_state_o) == PS_ENTERING && pwr_state_o == PS_DEEP) |-> (dwell_ent_q == T_DP)); // R4

  AST_EXIT_DWELL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pwr_state_o) == PS_LEAVING && pwr_state_o == PS_STANDBY) |-> (dwell_lv_q == T_RDP)); // R7

  AST_BUSY_HOLD_STBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == PS_STANDBY && busy_i) |=> (pwr_state_o == PS_STANDBY)); // R8

  AST_BUSY_HOLD_DEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == PS_DEEP && busy_i) |=> (pwr_state_o == PS_DEEP)); // R8

  AST_ERR_IN_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(proto_err_o) |-> ($past(pwr_state_o) == PS_LEAVING)); // R9
endmodule

bind flash_pwr_ctrl fpc_checker #(.T_DP(T_DP), .T_RDP(T_RDP)) u_fpc_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (busy_i),
  .pwr_state_o(pwr_state_o),
  .proto_err_o(proto_err_o)
);

// File: tb/flash_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_pwr_ctrl_tb_top;
  localparam int TDP  = 12;
  localparam int TRDP = 20;
  localparam logic [7:0] OP_EN  = 8'hB9;
  localparam logic [7:0] OP_REL = 8'hAB;
  localparam int SETTLE = TDP + TRDP + 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sclk_i = 1'b0, sdi_i = 1'b0, busy_i = 1'b0;
  logic [1:0] pwr_state_o;
  logic accept_cmd_o, proto_err_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  flash_pwr_ctrl #(.T_DP(TDP), .T_RDP(TRDP)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk_i), .sdi_i(sdi_i),
    .busy_i(busy_i), .pwr_state_o(pwr_state_o), .accept_cmd_o(accept_cmd_o),
    .proto_err_o(proto_err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_bits(input logic [7:0] op, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sdi_i = (i < 8) ? op[7-i] : 1'b0;
      tick(3); sclk_i = 1'b1; tick(3); sclk_i = 1'b0; tick(2);
    end
  endtask

  task automatic frame(input logic [7:0] op, input int nbits);
    cs_ni = 1'b0; tick(4);
    send_bits(op, nbits);
    tick(3); cs_ni = 1'b1; tick(4);
  endtask

  // raise cs, report edges until the state moves and the dwell in the new state
  task automatic end_and_time(output int lat, output int dwell, output int st1);
    int st0;
    st0 = pwr_state_o;
    cs_ni = 1'b1; lat = 0;
    do begin tick(1); lat++; end while (pwr_state_o == st0 && lat < 20);
    st1 = pwr_state_o; dwell = 1;
    forever begin
      tick(1);
      if (pwr_state_o == st1 && dwell < 5000) dwell++; else break;
    end
  endtask

  function automatic int model_next(input int st, input logic [7:0] op, input int nb, input bit bz);
    bit ok = (nb == 8) && !bz;
    if (st == 0 && ok && op == OP_EN)  return 2;
    if (st == 2 && ok && op == OP_REL) return 0;
    return st;
  endfunction

  task automatic go_deep();
    frame(OP_EN, 8); tick(SETTLE);
  endtask

  task automatic wait_state(input int st);
    int k = 0;
    while (pwr_state_o != st && k < 5000) begin tick(1); k++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lat, dwell, st1, js, exp_st;
    logic [7:0] op;
    int nb;
    bit bz;
    void'($urandom(32'd2024));

    tick(3);
    check(pwr_state_o == 2'b00, "R1 state", pwr_state_o, 0);
    check(accept_cmd_o == 1'b1, "R1 accept", accept_cmd_o, 1);
    check(proto_err_o == 1'b0, "R1 err", proto_err_o, 0);
    rst_ni = 1'b1; tick(2);
    check(pwr_state_o == 2'b00, "R1 after release", pwr_state_o, 0);

    frame(OP_REL, 8); tick(SETTLE);
    check(pwr_state_o == 2'b00, "R11 release in standby", pwr_state_o, 0);
    frame(8'h3C, 8); tick(SETTLE);
    check(pwr_state_o == 2'b00, "R11 other byte", pwr_state_o, 0);
    frame(OP_EN, 7); tick(SETTLE);
    check(pwr_state_o == 2'b00, "R3 short enter", pwr_state_o, 0);
    frame(OP_EN, 9); tick(SETTLE);
    check(pwr_state_o == 2'b00, "R3 long enter", pwr_state_o, 0);
    busy_i = 1'b1; frame(OP_EN, 8); tick(SETTLE); busy_i = 1'b0;
    check(pwr_state_o == 2'b00, "R8 enter while busy", pwr_state_o, 0);

    cs_ni = 1'b0; tick(4); send_bits(OP_EN, 8); tick(3);
    end_and_time(lat, dwell, st1);
    check(lat == 4, "R10 cs edge latency", lat, 4);
    check(st1 == 1, "R2 entering code", st1, 1);
    check(dwell == TDP, "R4 entry dwell", dwell, TDP);
    check(pwr_state_o == 2'b10, "R4 deep reached", pwr_state_o, 2);
    check(accept_cmd_o == 1'b0, "R2 accept low in deep", accept_cmd_o, 0);

    frame(OP_EN, 8); tick(SETTLE);
    check(pwr_state_o == 2'b10, "R5 enter in deep", pwr_state_o, 2);
    frame(8'h5A, 8); tick(SETTLE);
    check(pwr_state_o == 2'b10, "R5 other byte in deep", pwr_state_o, 2);
    frame(OP_REL, 7); tick(SETTLE);
    check(pwr_state_o == 2'b10, "R6 short release", pwr_state_o, 2);
    frame(OP_REL, 9); tick(SETTLE);
    check(pwr_state_o == 2'b10, "R6 long release", pwr_state_o, 2);
    busy_i = 1'b1; frame(OP_REL, 8); tick(SETTLE); busy_i = 1'b0;
    check(pwr_state_o == 2'b10, "R8 release while busy", pwr_state_o, 2);

    cs_ni = 1'b0; tick(4); send_bits(OP_REL, 8); tick(3);
    end_and_time(lat, dwell, st1);
    check(lat == 4, "R10 release latency", lat, 4);
    check(st1 == 3, "R2 leaving code", st1, 3);
    check(dwell == TRDP, "R7 exit dwell", dwell, TRDP);
    check(pwr_state_o == 2'b00, "R7 standby reached", pwr_state_o, 0);
    check(accept_cmd_o == 1'b1, "R2 accept in standby", accept_cmd_o, 1);

    // R12: frame opened during entry, closed in deep
    frame(OP_EN, 8); wait_state(1);
    cs_ni = 1'b0; tick(4); wait_state(2); send_bits(OP_REL, 8); tick(3); cs_ni = 1'b1;
    tick(SETTLE);
    check(pwr_state_o == 2'b10, "R12 frame from entering dropped", pwr_state_o, 2);

    // R9: frame opened during exit
    frame(OP_REL, 8); wait_state(3);
    cs_ni = 1'b0; tick(6);
    check(proto_err_o == 1'b1, "R9 err set", proto_err_o, 1);
    wait_state(0);
    send_bits(OP_EN, 8); tick(3); cs_ni = 1'b1; tick(SETTLE);
    check(pwr_state_o == 2'b00, "R9 stray frame dropped", pwr_state_o, 0);
    check(proto_err_o == 1'b1, "R9 err sticky", proto_err_o, 1);
    frame(8'h00, 8); tick(4);
    check(proto_err_o == 1'b0, "R9 err cleared in standby", proto_err_o, 0);

    // boundary sweep: cs fall judged near the end of the exit wait
    for (int off = TRDP - 6; off <= TRDP + 1; off++) begin
      go_deep();
      frame(OP_REL, 8);
      wait_state(3);
      tick(off - 4 > 0 ? off - 4 : 0);
      cs_ni = 1'b0; tick(3);
      js = pwr_state_o; tick(3);
      check(proto_err_o == (js == 3), "R9 boundary err", proto_err_o, (js == 3));
      cs_ni = 1'b1; tick(SETTLE);
      check(pwr_state_o == 2'b00, "R9 boundary standby", pwr_state_o, 0);
      frame(8'h00, 8); tick(4);
    end

    // random traffic against the model
    exp_st = pwr_state_o;
    for (int it = 0; it < 60; it++) begin
      case ($urandom % 3)
        0: op = OP_EN;
        1: op = OP_REL;
        default: op = 8'($urandom);
      endcase
      case ($urandom % 4)
        0: nb = 7;
        1: nb = 9;
        default: nb = 8;
      endcase
      bz = (($urandom % 5) == 0);
      busy_i = bz;
      frame(op, nb); tick(SETTLE);
      busy_i = 1'b0;
      exp_st = model_next(exp_st, op, nb, bz);
      check(pwr_state_o == 2'(exp_st), "R3 R5 R8 random state", pwr_state_o, exp_st);
      check(accept_cmd_o == (exp_st == 0), "R2 random accept", accept_cmd_o, (exp_st == 0));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule